// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block changes the multiplier and post-divider of a clock PLL without letting an unstable clock reach the logic it feeds. A one-cycle start pulse captures the requested multiplier and divider. The sequencer then drives a simple register port to the PLL and works through a fixed order of steps:

1. Put the output into bypass.
2. Hold the PLL in reset.
3. Program the multiplier, then the divider.
4. Wait at least one microsecond.
5. Release reset.
6. Poll the lock flag.
7. Switch the output back to the PLL only once lock is seen.

If lock never arrives, the block raises a timeout flag and leaves the clock in bypass. The register port has a single-cycle write strobe with address and data. It also has a read request whose data comes back on the next cycle. The control register uses fixed bit meanings:

| Bit | Meaning |
|-----|---------|
| 0 | PLL enable (cleared means bypass) |
| 3 | PLL reset |
| 5 | Lock flag (read only) |
| 6 | Kept set in every write |

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset, `busy`, `done`, `timeout`, `regWrEn` and `regRdEn` are all low, and no register access happens until a start pulse arrives.
- R2: The first write after a start goes to `CSR_ADDR` with data 0x0040. This clears enable bit 0 (bypass) and keeps bit 6 set.
- R3: The second write goes to `CSR_ADDR` with data 0x0048, which sets reset bit 3 while still bypassed.
- R4: The third write goes to `MUL_ADDR` with the captured multiplier zero-extended. The fourth write goes to `DIV_ADDR` with bit 15 set and the captured divider in the low bits. Neither write happens unless the last control value written had bit 3 set and bit 0 clear.
- R5: The reset-release write comes exactly `HOLD_CYC`+1 cycles after the divider write, where `HOLD_CYC` = ceil(`REF_CLK_KHZ`/1000) is the number of reference cycles in 1 µs.
- R6: The fifth write goes to `CSR_ADDR` with data 0x0040, which releases reset and keeps bypass.
- R7: After release, the block issues read requests to `CSR_ADDR`. Each read's data is examined one cycle later, and bit 5 is taken as lock. Reads repeat while lock is 0, and a write never coincides with a read.
- R8: The sixth write goes to `CSR_ADDR` with data 0x0041 (enable set). It happens only after a read returned lock = 1. `done` is high for exactly that one cycle.
- R9: If no lock is read within `LOCK_TMO_CYC` cycles of the release write, `timeout` pulses for one cycle. The block then returns to idle with no enable write made, and `done` stays low.
- R10: A start pulse that arrives while `busy` is high is ignored. The running sequence keeps its captured values and makes no extra writes.
- R11: `busy` is high from the cycle after an accepted start through the cycle that carries `done` or `timeout`, including every cycle with a register write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | One-cycle request to reprogram |
| mulIn | input | MUL_W | Requested multiplier field |
| divIn | input | DIV_W | Requested post-divider ratio field |
| regWrEn | output | 1 | Single-cycle register write strobe |
| regAddr | output | ADDR_W | Register address for write or read |
| regWrData | output | 16 | Register write data |
| regRdEn | output | 1 | Read request; data returns next cycle |
| regRdData | input | 16 | Read data from the PLL register block |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| timeout | output | 1 | One-cycle pulse when lock never arrived |

## Verification
Random multiplier and divider values with random lock delays check the whole write order. They also check the exact hold gap and the data fields, and separate a correct field mapping from a swapped or truncated one. A lock delay of zero shows that enable waits for a real poll result rather than a fixed delay. A lock that never comes distinguishes the timeout path, which must leave bypass set, from the success path. A second start during a run, carrying different values, shows whether the captured settings or the write count can be disturbed.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  localparam int DATA_W = 16;
  localparam logic [DATA_W-1:0] CSR_BYPASS = 16'h0040;
  localparam logic [DATA_W-1:0] CSR_HOLDRST = 16'h0048;
  localparam logic [DATA_W-1:0] CSR_RUN = 16'h0041;
  localparam int DIV_ENABLE_BIT = 15;
  localparam int LOCK_BIT = 5;
  localparam int RST_BIT = 3;
  localparam int EN_BIT = 0;

  typedef enum logic [2:0] {
    SEL_BYP, SEL_RST, SEL_MUL, SEL_DIV, SEL_REL, SEL_EN
  } wrSel_e;

  typedef enum logic [3:0] {
    S_IDLE, S_BYP, S_RST, S_MUL, S_DIV, S_HOLD,
    S_REL, S_PREQ, S_PWAIT, S_EN, S_TOUT
  } seqState_e;

  typedef struct packed {
    logic   capture;
    logic   cntClr;
    logic   wrEn;
    wrSel_e wrSel;
    logic   rdEn;
  } seqStrobe_t;
endpackage

// File: rtl/pll_seq_dpath.sv
module pll_seq_dpath
  import pll_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int MUL_W = 5,
  parameter int DIV_W = 5,
  parameter logic [ADDR_W-1:0] CSR_ADDR = 'h0,
  parameter logic [ADDR_W-1:0] MUL_ADDR = 'h1,
  parameter logic [ADDR_W-1:0] DIV_ADDR = 'h2,
  parameter int HOLD_CYC = 25,
  parameter int LOCK_TMO_CYC = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic              busy,
  input  logic [MUL_W-1:0]  mulIn,
  input  logic [DIV_W-1:0]  divIn,
  input  logic [DATA_W-1:0] regRdData,
  output logic              regWrEn,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regRdEn,
  output logic              holdDone,
  output logic              tmoHit,
  output logic              lockSeen
);
  localparam int CNT_MAX = (HOLD_CYC > LOCK_TMO_CYC) ? HOLD_CYC : LOCK_TMO_CYC;
  localparam int CNT_W = $clog2(CNT_MAX + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(CNT_MAX + 1);

  logic [MUL_W-1:0]  mulQ;
  logic [DIV_W-1:0]  divQ;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] csrShadow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mulQ <= '0;
      divQ <= '0;
    end else if (strb.capture) begin
      mulQ <= mulIn;
      divQ <= divIn;
    end
  end

  // One counter serves both the reset-hold window and the lock timeout
  always_ff @(posedge clk) begin
    if (!rstN || strb.cntClr) cnt <= '0;
    else if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
  end

  assign holdDone = (cnt == CNT_W'(HOLD_CYC - 1));
  assign tmoHit   = (cnt >= CNT_W'(LOCK_TMO_CYC));
  assign lockSeen = regRdData[LOCK_BIT];

  always_comb begin
    regAddr   = CSR_ADDR;
    regWrData = CSR_BYPASS;
    case (strb.wrSel)
      SEL_BYP: regWrData = CSR_BYPASS;
      SEL_RST: regWrData = CSR_HOLDRST;
      SEL_MUL: begin
        regAddr   = MUL_ADDR;
        regWrData = {{(DATA_W-MUL_W){1'b0}}, mulQ};
      end
      SEL_DIV: begin
        regAddr   = DIV_ADDR;
        regWrData = {{(DATA_W-DIV_W){1'b0}}, divQ};
        regWrData[DIV_ENABLE_BIT] = 1'b1;
      end
      SEL_REL: regWrData = CSR_BYPASS;
      SEL_EN:  regWrData = CSR_RUN;
      default: regWrData = CSR_BYPASS;
    endcase
  end

  assign regWrEn = strb.wrEn;
  assign regRdEn = strb.rdEn;

  always_ff @(posedge clk) begin
    if (!rstN) csrShadow <= '0;
    else if (regWrEn && regAddr == CSR_ADDR) csrShadow <= regWrData;
  end

  p_prog_in_reset_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr != CSR_ADDR) |-> (csrShadow[RST_BIT] && !csrShadow[EN_BIT]));

  p_no_rd_wr_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regRdEn));

  p_ignore_start_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(mulQ) && $stable(divQ)));
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       holdDone,
  input  logic       tmoHit,
  input  logic       lockSeen,
  output seqStrobe_t strb,
  output logic       busy,
  output logic       done,
  output logic       timeout
);
  seqState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else state <= nextState;
  end

  always_comb begin
    nextState    = state;
    strb         = '0;
    strb.wrSel   = SEL_BYP;
    case (state)
      S_IDLE: if (startReq) begin
        strb.capture = 1'b1;
        nextState    = S_BYP;
      end
      S_BYP: begin
        strb.wrEn = 1'b1; strb.wrSel = SEL_BYP; nextState = S_RST;
      end
      S_RST: begin
        strb.wrEn = 1'b1; strb.wrSel = SEL_RST; nextState = S_MUL;
      end
      S_MUL: begin
        strb.wrEn = 1'b1; strb.wrSel = SEL_MUL; nextState = S_DIV;
      end
      S_DIV: begin
        strb.wrEn = 1'b1; strb.wrSel = SEL_DIV; strb.cntClr = 1'b1;
        nextState = S_HOLD;
      end
      S_HOLD: if (holdDone) nextState = S_REL;
      S_REL: begin
        strb.wrEn = 1'b1; strb.wrSel = SEL_REL; strb.cntClr = 1'b1;
        nextState = S_PREQ;
      end
      S_PREQ: begin
        strb.rdEn = 1'b1; nextState = S_PWAIT;
      end
      S_PWAIT: begin
        if (lockSeen) nextState = S_EN;
        else if (tmoHit) nextState = S_TOUT;
        else nextState = S_PREQ;
      end
      S_EN: begin
        strb.wrEn = 1'b1; strb.wrSel = SEL_EN; nextState = S_IDLE;
      end
      S_TOUT: nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign busy    = (state != S_IDLE);
  assign done    = (state == S_EN);
  assign timeout = (state == S_TOUT);

  p_enable_after_lock_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_EN) |-> ($past(state) == S_PWAIT && $past(lockSeen)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(done && timeout));

  p_busy_on_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |-> busy);
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int MUL_W = 5,
  parameter int DIV_W = 5,
  parameter logic [ADDR_W-1:0] CSR_ADDR = 'h0,
  parameter logic [ADDR_W-1:0] MUL_ADDR = 'h1,
  parameter logic [ADDR_W-1:0] DIV_ADDR = 'h2,
  parameter int REF_CLK_KHZ = 25000,
  parameter int LOCK_TMO_CYC = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [MUL_W-1:0]  mulIn,
  input  logic [DIV_W-1:0]  divIn,
  output logic              regWrEn,
  output logic [ADDR_W-1:0] regAddr,
  output logic [15:0]       regWrData,
  output logic              regRdEn,
  input  logic [15:0]       regRdData,
  output logic              busy,
  output logic              done,
  output logic              timeout
);
  localparam int HOLD_RAW = (REF_CLK_KHZ + 999) / 1000;
  localparam int HOLD_CYC = (HOLD_RAW < 1) ? 1 : HOLD_RAW;

  seqStrobe_t strb;
  logic holdDone, tmoHit, lockSeen;

  pll_seq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .holdDone(holdDone), .tmoHit(tmoHit), .lockSeen(lockSeen),
    .strb(strb), .busy(busy), .done(done), .timeout(timeout)
  );

  pll_seq_dpath #(
    .ADDR_W(ADDR_W), .MUL_W(MUL_W), .DIV_W(DIV_W),
    .CSR_ADDR(CSR_ADDR), .MUL_ADDR(MUL_ADDR), .DIV_ADDR(DIV_ADDR),
    .HOLD_CYC(HOLD_CYC), .LOCK_TMO_CYC(LOCK_TMO_CYC)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy),
    .mulIn(mulIn), .divIn(divIn), .regRdData(regRdData),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdEn(regRdEn), .holdDone(holdDone), .tmoHit(tmoHit),
    .lockSeen(lockSeen)
  );
endmodule

// File: tb/test_pll_reprog_seq.sv
module test_pll_reprog_seq;
  localparam int ADDR_W = 8;
  localparam int MUL_W = 5;
  localparam int DIV_W = 5;
  localparam logic [7:0] CSR_A = 8'h10;
  localparam logic [7:0] MUL_A = 8'h11;
  localparam logic [7:0] DIV_A = 8'h12;
  localparam int REF_KHZ = 24500;
  localparam int HOLD = 25;
  localparam int TMO = 64;
  localparam int NEVER = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [MUL_W-1:0] mulIn = '0;
  logic [DIV_W-1:0] divIn = '0;
  logic regWrEn, regRdEn, busy, done, timeout;
  logic [ADDR_W-1:0] regAddr;
  logic [15:0] regWrData;
  logic [15:0] regRdData = '0;

  always #5 clk = ~clk;

  pll_reprog_seq #(
    .ADDR_W(ADDR_W), .MUL_W(MUL_W), .DIV_W(DIV_W),
    .CSR_ADDR(CSR_A), .MUL_ADDR(MUL_A), .DIV_ADDR(DIV_A),
    .REF_CLK_KHZ(REF_KHZ), .LOCK_TMO_CYC(TMO)
  ) i_pll_reprog_seq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .mulIn(mulIn), .divIn(divIn),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData),
    .busy(busy), .done(done), .timeout(timeout)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // PLL register model, sampled and driven on the falling edge
  int cyc = 0;
  int nWr = 0, nRd = 0, nDone = 0, nTo = 0, nBusyBad = 0;
  logic [7:0]  wrAddr [0:255];
  logic [15:0] wrData [0:255];
  int          wrCyc  [0:255];
  int lockDelay = 0;
  bit inReset = 0, released = 0;
  int relCyc = 0, lockCyc = -1;
  logic [15:0] csrModel = '0;
  bit lockNow;

  always @(negedge clk) begin
    cyc = cyc + 1;
    lockNow = released && !inReset && ((cyc - relCyc) >= lockDelay);
    if (lockNow && lockCyc < 0) lockCyc = cyc;
    if (regWrEn) begin
      if (!busy) nBusyBad = nBusyBad + 1;
      wrAddr[nWr[7:0]] = regAddr;
      wrData[nWr[7:0]] = regWrData;
      wrCyc[nWr[7:0]]  = cyc;
      nWr = nWr + 1;
      if (regAddr == CSR_A) begin
        csrModel = regWrData;
        if (regWrData[3]) begin
          inReset = 1; released = 0; lockCyc = -1;
        end else if (inReset) begin
          inReset = 0; released = 1; relCyc = cyc;
        end
      end
    end
    if (regRdEn) begin
      nRd = nRd + 1;
      regRdData <= (csrModel & 16'hFFDF) | (lockNow ? 16'h0020 : 16'h0000);
    end
    if (done) nDone = nDone + 1;
    if (timeout) nTo = nTo + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] expWr(input int idx, input logic [MUL_W-1:0] m,
                                        input logic [DIV_W-1:0] d);
    case (idx)
      0: return {CSR_A, 16'h0040};
      1: return {CSR_A, 16'h0048};
      2: return {MUL_A, 11'd0, m};
      3: return {DIV_A, 1'b1, 10'd0, d};
      4: return {CSR_A, 16'h0040};
      default: return {CSR_A, 16'h0041};
    endcase
  endfunction

  task automatic runSeq(input logic [MUL_W-1:0] m, input logic [DIV_W-1:0] d,
                        input int delay, input bit inject);
    int b0, r0, d0, t0, k, n;
    bit expLock;
    logic [23:0] e;
    expLock = (delay < TMO - 2);
    lockDelay = delay;
    b0 = nWr; r0 = nRd; d0 = nDone; t0 = nTo;
    @(negedge clk);
    startReq = 1; mulIn = m; divIn = d;
    @(negedge clk);
    startReq = 0;
    k = 0;
    while (busy && k < 2000) begin
      @(negedge clk);
      k++;
      if (inject && k == 4) begin startReq = 1; mulIn = ~m; divIn = ~d; end
      if (inject && k == 5) startReq = 0;
    end
    repeat (3) @(negedge clk);
    chk(k < 2000, "R11", "busy fell", k, 0);
    n = nWr - b0;
    if (expLock) begin
      chk(n == 6, inject ? "R10" : "R8", "write count", n, 6);
      chk(nDone - d0 == 1, "R8", "done pulses", nDone - d0, 1);
      chk(nTo == t0, "R9", "no timeout on lock", nTo - t0, 0);
      chk(wrCyc[(b0 + 5) % 256] > lockCyc, "R8", "enable after lock", wrCyc[(b0 + 5) % 256], lockCyc);
    end else begin
      chk(n == 5, "R9", "no enable write", n, 5);
      chk(nTo - t0 == 1, "R9", "timeout pulses", nTo - t0, 1);
      chk(nDone == d0, "R9", "no done", nDone - d0, 0);
    end
    chk(nRd - r0 >= 1, "R7", "poll reads", nRd - r0, 1);
    for (int i = 0; i < 6 && i < n; i++) begin
      e = expWr(i, m, d);
      chk(wrAddr[(b0 + i) % 256] == e[23:16], i < 2 ? "R2" : (i < 4 ? "R4" : "R6"),
          "write addr", wrAddr[(b0 + i) % 256], e[23:16]);
      chk(wrData[(b0 + i) % 256] == e[15:0],
          i == 0 ? "R2" : i == 1 ? "R3" : i < 4 ? "R4" : i == 4 ? "R6" : "R8",
          "write data", wrData[(b0 + i) % 256], e[15:0]);
    end
    if (n >= 5)
      chk(wrCyc[(b0 + 4) % 256] - wrCyc[(b0 + 3) % 256] == HOLD + 1, "R5", "hold gap",
          wrCyc[(b0 + 4) % 256] - wrCyc[(b0 + 3) % 256], HOLD + 1);
    chk(nBusyBad == 0, "R11", "busy during writes", nBusyBad, 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1: reset state and no accesses while idle
    chk(!busy && !done && !timeout && !regWrEn && !regRdEn, "R1", "held in reset",
        {busy, done, timeout, regWrEn, regRdEn}, 0);
    rstN = 1;
    repeat (5) @(negedge clk);
    chk(nWr == 0 && nRd == 0 && !busy, "R1", "idle after reset", nWr + nRd, 0);
    runSeq(5'd3, 5'd0, 0, 0);         // lock immediately on first poll
    runSeq(5'd31, 5'd31, 7, 1);       // start while busy ignored (R10)
    runSeq(5'd9, 5'd4, NEVER, 0);     // lock never arrives
    runSeq(5'd1, 5'd2, 20, 0);        // recovers after a timeout
    for (int t = 0; t < 20; t++) begin
      logic [MUL_W-1:0] rm;
      logic [DIV_W-1:0] rd;
      rm = MUL_W'($urandom);
      rd = DIV_W'($urandom);
      runSeq(rm, rd, int'($urandom % 40), ($urandom % 4) == 0);
    end
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(150000 * 10);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule